// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

The block takes interrupt events from on-chip sources, one at a time through a valid/ready handshake. It packs each event into a 128-bit vector and stores that vector into a circular buffer held in system memory, using a simple single-beat memory-write port. A byte-counting write pointer advances by 16 after every stored vector. It wraps at a ring size that software programs as a power of two.

Host software consumes vectors and moves a read pointer forward. While the two pointers differ, the block holds an interrupt level toward the host. It also emits a one-cycle message pulse when the ring goes from empty to non-empty. When the ring is full, the block keeps writing rather than stalling and sets a sticky overflow flag that software can read and clear. As an option, each new write-pointer value is also stored to a writeback location in memory, so the host can poll memory instead of registers.

Top module: `ivring_writer`

## Requirements
- R1: Vector layout. Bits [7:0] carry the source id. Bits [59:32] carry the 28-bit source data. Bits [71:64] carry the ring id, bits [79:72] the VMID and bits [95:80] the PASID. All other bits are written as zero.
- R2: Register map (address, content):
  - 0: control. Bit 0 is ring enable and bits [5:1] hold the log2 of the ring size in 32-bit words.
  - 1: interrupt config.
  - 2: base, which holds the memory address shifted right by 8.
  - 3: read pointer.
  - 4: write pointer.
  - 5: writeback address.
  
  Each vector goes to base*256 + write pointer. After it is accepted by memory, the write pointer becomes (wptr+16) AND ((4 << log2) - 1).
- R3: An event is taken only while the ring is enabled and no memory write is outstanding. Otherwise evt_ready is low, and a pending memory request holds its address and kind until mem_ready.
- R4: When control bit 6 (overflow detect) is set and the masked next write pointer equals the read pointer, the vector is still written and the pointer still advances. Bit 31 of the write-pointer read value becomes 1.
- R5: The overflow flag stays set until control bit 7 (overflow clear) is 1. While that bit is held, the flag reads 0 and cannot be set.
- R6: When control bit 8 (writeback) is set, each write-pointer advance is followed by one memory write with mem_is_wb=1. That write goes to the writeback register value times 4, and its low 32 data bits are the write-pointer read value.
- R7: irq_pending equals interrupt-config bit 0 (interrupt enable) AND (read pointer != write pointer).
- R8: With interrupt enable set, irq_msg pulses for one cycle in the cycle after the ring goes from idle to non-idle.
- R9: With interrupt-config bit 1 (rearm) set, a host read-pointer write that leaves unread entries pulses irq_msg once. Without rearm, such a write produces no pulse.
- R10: Host writes to the read or write pointer load the value ANDed with the ring mask, and both read back through the register interface.
- R11: After reset, every register and pointer is zero and evt_ready, busy and irq outputs are low. busy is high while a vector or writeback write is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event taken this cycle when valid |
| evt_src | input | 8 | Source id |
| evt_data | input | 28 | Source data |
| evt_ring | input | 8 | Ring id |
| evt_vmid | input | 8 | VMID |
| evt_pasid | input | 16 | PASID |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 40 | Byte address of the write |
| mem_wdata | output | 128 | Write data |
| mem_is_wb | output | 1 | Request is a write-pointer writeback |
| irq_pending | output | 1 | Unread entries exist and interrupts are enabled |
| irq_msg | output | 1 | One-cycle interrupt message pulse |
| busy | output | 1 | Memory write outstanding |

## Verification
A vector commit and a host read-pointer write can land in the same clock. The overflow test must then compare against the freshly written read pointer, and the idle test for the interrupt must use both new values. The bench holds mem_ready low to park a vector request. It then raises mem_ready in the same cycle as a read-pointer write that makes the advanced write pointer meet it. It expects the overflow flag to be set, the ring to read as idle with irq_pending low, no extra irq_msg pulse, and a writeback value that carries the flag.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = REG_W + 8;
    localparam int VEC_W   = 128;
    localparam int LOG2_W  = 5;
    localparam int VEC_BYTES = VEC_W / 8;
    localparam int OVF_BIT = REG_W - 1;

    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_IRQCFG = 3'd1;
    localparam logic [2:0] RA_BASE   = 3'd2;
    localparam logic [2:0] RA_RPTR   = 3'd3;
    localparam logic [2:0] RA_WPTR   = 3'd4;
    localparam logic [2:0] RA_WBADDR = 3'd5;

    localparam int CB_RING_EN = 0;
    localparam int CB_SIZE_LO = 1;
    localparam int CB_OVF_EN  = 6;
    localparam int CB_OVF_CLR = 7;
    localparam int CB_WB_EN   = 8;
    localparam int IB_INTR_EN = 0;
    localparam int IB_REARM   = 1;

    typedef struct packed {
        logic [7:0]  src;
        logic [27:0] data;
        logic [7:0]  ring;
        logic [7:0]  vmid;
        logic [15:0] pasid;
    } ivr_event_t;

    typedef struct packed {
        logic              ring_en;
        logic [LOG2_W-1:0] size_log2;
        logic              ovf_en;
        logic              ovf_clr;
        logic              wb_en;
        logic              intr_en;
        logic              rearm;
    } ivr_cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_WB} ivr_state_e;
endpackage

// File: rtl/ivr_pack.sv
module ivr_pack
    import ivr_pkg::*;
(
    input  ivr_event_t       evt,
    output logic [VEC_W-1:0] vec
);
    localparam int SRC_LO  = 0;
    localparam int DATA_LO = 32;
    localparam int RING_LO = 64;
    localparam int VMID_LO = 72;
    localparam int PAS_LO  = 80;

    always_comb begin
        vec = '0;
        vec[SRC_LO  +: 8]  = evt.src;
        vec[DATA_LO +: 28] = evt.data;
        vec[RING_LO +: 8]  = evt.ring;
        vec[VMID_LO +: 8]  = evt.vmid;
        vec[PAS_LO  +: 16] = evt.pasid;
    end
endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [PTR_W-1:0]  rptr,
    input  logic              ovf,
    output ivr_cfg_t          cfg,
    output logic [REG_W-1:0]  base,
    output logic [REG_W-1:0]  wbaddr,
    output logic              rptr_wr,
    output logic              wptr_wr,
    output logic [PTR_W-1:0]  ptr_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam int PAD_W = REG_W - 1 - PTR_W;

    typedef struct packed {
        ivr_cfg_t         cfg;
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] wbaddr;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_wr) begin
            unique case (reg_addr)
                RA_CTRL: begin
                    d.cfg.ring_en   = reg_wdata[CB_RING_EN];
                    d.cfg.size_log2 = reg_wdata[CB_SIZE_LO +: LOG2_W];
                    d.cfg.ovf_en    = reg_wdata[CB_OVF_EN];
                    d.cfg.ovf_clr   = reg_wdata[CB_OVF_CLR];
                    d.cfg.wb_en     = reg_wdata[CB_WB_EN];
                end
                RA_IRQCFG: begin
                    d.cfg.intr_en = reg_wdata[IB_INTR_EN];
                    d.cfg.rearm   = reg_wdata[IB_REARM];
                end
                RA_BASE:   d.base   = reg_wdata;
                RA_WBADDR: d.wbaddr = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg       = q.cfg;
    assign base      = q.base;
    assign wbaddr    = q.wbaddr;
    assign rptr_wr   = reg_wr && (reg_addr == RA_RPTR);
    assign wptr_wr   = reg_wr && (reg_addr == RA_WPTR);
    assign ptr_wdata = reg_wdata[PTR_W-1:0];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_RING_EN]             = q.cfg.ring_en;
                reg_rdata[CB_SIZE_LO +: LOG2_W]   = q.cfg.size_log2;
                reg_rdata[CB_OVF_EN]              = q.cfg.ovf_en;
                reg_rdata[CB_OVF_CLR]             = q.cfg.ovf_clr;
                reg_rdata[CB_WB_EN]               = q.cfg.wb_en;
            end
            RA_IRQCFG: begin
                reg_rdata[IB_INTR_EN] = q.cfg.intr_en;
                reg_rdata[IB_REARM]   = q.cfg.rearm;
            end
            RA_BASE:   reg_rdata = q.base;
            RA_RPTR:   reg_rdata = {{(REG_W-PTR_W){1'b0}}, rptr};
            RA_WPTR:   reg_rdata = {ovf, {PAD_W{1'b0}}, wptr};
            RA_WBADDR: reg_rdata = q.wbaddr;
            default:   reg_rdata = '0;
        endcase
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CTRL) |=> (cfg.ring_en == $past(reg_wdata[CB_RING_EN]))); // R2
endmodule

// File: rtl/ivr_core.sv
module ivr_core
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ivr_cfg_t          cfg,
    input  logic [REG_W-1:0]  base,
    input  logic [REG_W-1:0]  wbaddr,
    input  logic              rptr_wr,
    input  logic              wptr_wr,
    input  logic [PTR_W-1:0]  ptr_wdata,
    input  logic              evt_valid,
    input  ivr_event_t        evt_in,
    output logic              evt_ready,
    output ivr_event_t        evt_held,
    input  logic [VEC_W-1:0]  vec,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [VEC_W-1:0]  mem_wdata,
    output logic              mem_is_wb,
    output logic [PTR_W-1:0]  wptr,
    output logic [PTR_W-1:0]  rptr,
    output logic              ovf,
    output logic              irq_pending,
    output logic              irq_msg,
    output logic              busy
);
    localparam int SH_W  = $clog2(PTR_W + 1) + 1;
    localparam int PAD_W = REG_W - 1 - PTR_W;

    typedef struct packed {
        ivr_state_e        state;
        ivr_event_t        evt;
        logic [ADDR_W-1:0] addr;
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic              ovf;
        logic              irq_msg;
    } core_t;

    core_t q, d;

    function automatic logic [PTR_W-1:0] ptr_mask(input logic [LOG2_W-1:0] lg);
        logic [SH_W-1:0]  sh;
        logic [PTR_W:0]   one_sh;
        sh = SH_W'(lg) + SH_W'(2);
        if (sh > SH_W'(PTR_W)) sh = SH_W'(PTR_W);
        one_sh = (PTR_W+1)'(1) << sh;
        return one_sh[PTR_W-1:0] - PTR_W'(1);
    endfunction

    logic [PTR_W-1:0] mask, rptr_eff, wptr_next;
    logic             commit, ovf_hit, pend_now, pend_next;

    always_comb begin
        d         = q;
        d.irq_msg = 1'b0;
        mask      = ptr_mask(cfg.size_log2);
        rptr_eff  = rptr_wr ? (ptr_wdata & mask) : q.rptr;
        d.rptr    = rptr_eff;
        if (wptr_wr) d.wptr = ptr_wdata & mask;
        wptr_next = (q.wptr + PTR_W'(VEC_BYTES)) & mask;
        commit    = (q.state == ST_VEC) && mem_ready;
        ovf_hit   = commit && cfg.ovf_en && (wptr_next == rptr_eff);

        unique case (q.state)
            ST_IDLE: if (evt_valid && cfg.ring_en) begin
                d.evt   = evt_in;
                d.addr  = {base, 8'h00} + ADDR_W'(q.wptr);
                d.state = ST_VEC;
            end
            ST_VEC: if (mem_ready) begin
                d.wptr  = wptr_next;
                d.state = cfg.wb_en ? ST_WB : ST_IDLE;
            end
            ST_WB: if (mem_ready) d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase

        if (cfg.ovf_clr)  d.ovf = 1'b0;
        else if (ovf_hit) d.ovf = 1'b1;

        pend_now  = (q.rptr != q.wptr);
        pend_next = (d.rptr != d.wptr);
        d.irq_msg = cfg.intr_en && pend_next && (!pend_now || (cfg.rearm && rptr_wr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign evt_ready   = (q.state == ST_IDLE) && cfg.ring_en;
    assign evt_held    = q.evt;
    assign mem_valid   = (q.state != ST_IDLE);
    assign mem_is_wb   = (q.state == ST_WB);
    assign mem_addr    = mem_is_wb ? ADDR_W'({wbaddr, 2'b00}) : q.addr;
    assign mem_wdata   = mem_is_wb ? VEC_W'({q.ovf, {PAD_W{1'b0}}, q.wptr}) : vec;
    assign wptr        = q.wptr;
    assign rptr        = q.rptr;
    assign ovf         = q.ovf;
    assign irq_pending = cfg.intr_en && (q.rptr != q.wptr);
    assign irq_msg     = q.irq_msg;
    assign busy        = mem_valid;

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready) |=> busy); // R3
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_is_wb))); // R3
    AST_MSG_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg |-> (wptr != rptr)); // R8
    AST_OVF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.ovf_clr |=> !ovf); // R5
    AST_WB_AFTER_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_is_wb && cfg.wb_en) |=> mem_is_wb); // R6
endmodule

// File: rtl/ivring_writer.sv
module ivring_writer
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    output logic               evt_ready,
    input  logic [7:0]         evt_src,
    input  logic [27:0]        evt_data,
    input  logic [7:0]         evt_ring,
    input  logic [7:0]         evt_vmid,
    input  logic [15:0]        evt_pasid,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [39:0]        mem_addr,
    output logic [127:0]       mem_wdata,
    output logic               mem_is_wb,
    output logic               irq_pending,
    output logic               irq_msg,
    output logic               busy
);
    ivr_cfg_t         cfg;
    logic [REG_W-1:0] base, wbaddr;
    logic             rptr_wr, wptr_wr, ovf;
    logic [PTR_W-1:0] ptr_wdata, wptr, rptr;
    ivr_event_t       evt_in, evt_held;
    logic [VEC_W-1:0] vec;

    assign evt_in = '{src: evt_src, data: evt_data, ring: evt_ring,
                      vmid: evt_vmid, pasid: evt_pasid};

    ivr_regs #(.PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .wptr(wptr), .rptr(rptr), .ovf(ovf),
        .cfg(cfg), .base(base), .wbaddr(wbaddr), .rptr_wr(rptr_wr),
        .wptr_wr(wptr_wr), .ptr_wdata(ptr_wdata), .reg_rdata(reg_rdata)
    );

    ivr_pack u_pack (.evt(evt_held), .vec(vec));

    ivr_core #(.PTR_W(PTR_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .base(base), .wbaddr(wbaddr),
        .rptr_wr(rptr_wr), .wptr_wr(wptr_wr), .ptr_wdata(ptr_wdata),
        .evt_valid(evt_valid), .evt_in(evt_in), .evt_ready(evt_ready),
        .evt_held(evt_held), .vec(vec), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_is_wb(mem_is_wb), .wptr(wptr), .rptr(rptr), .ovf(ovf),
        .irq_pending(irq_pending), .irq_msg(irq_msg), .busy(busy)
    );
endmodule

// File: tb/tb_ivring_writer.sv
`timescale 1ns/1ps
module tb_ivring_writer;
    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic evt_valid = 0, reg_wr = 0, mem_ready = 0;
    logic [7:0] evt_src = 0, evt_ring = 0, evt_vmid = 0;
    logic [27:0] evt_data = 0;
    logic [15:0] evt_pasid = 0;
    logic [2:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic evt_ready, mem_valid, mem_is_wb, irq_pending, irq_msg, busy;
    logic [39:0] mem_addr;
    logic [127:0] mem_wdata;

    ivring_writer dut (.*);

    int checks = 0, failures = 0, msg_cnt = 0, vec_cnt = 0, wb_cnt = 0;
    logic hold_ready = 0, done = 0;
    logic [39:0] last_vaddr = 0, last_wbaddr = 0;
    logic [127:0] last_vec = 0;
    logic [31:0] last_wb = 0;

    localparam logic [39:0] BASE_ADDR = 40'h12_3400;
    localparam logic [31:0] CTRL_RUN = 32'h49;

    // src, data, ring, vmid, pasid, expected write-pointer read value
    localparam logic [99:0] TBL [4] = '{
        {8'h11, 28'h0ABCDEF, 8'h21, 8'h31, 16'h4141, 32'h0000_0010},
        {8'hFF, 28'hFFFFFFF, 8'hFF, 8'hFF, 16'hFFFF, 32'h0000_0020},
        {8'h00, 28'h0000001, 8'h80, 8'h01, 16'h8001, 32'h0000_0030},
        {8'h5A, 28'h5A5A5A5, 8'hA5, 8'h3C, 16'hC3C3, 32'h8000_0000}
    };

    function automatic logic [127:0] pack(input logic [7:0] s, input logic [27:0] dt,
                                          input logic [7:0] rg, input logic [7:0] vm,
                                          input logic [15:0] ps);
        logic [127:0] v = '0;
        v[7:0] = s; v[59:32] = dt; v[71:64] = rg; v[79:72] = vm; v[95:80] = ps;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5 v = reg_rdata;
        @(negedge clk);
    endtask

    task automatic send_event(input logic [99:0] e);
        {evt_src, evt_data, evt_ring, evt_vmid, evt_pasid} = e[99:32];
        evt_valid = 1;
        while (!evt_ready) @(negedge clk);
        @(negedge clk);
        evt_valid = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // memory responder
    initial forever begin
        @(negedge clk);
        if (!hold_ready) begin
            if (mem_ready) mem_ready = 0;
            else if (mem_valid) begin
                if (mem_is_wb) begin wb_cnt++; last_wb = mem_wdata[31:0]; last_wbaddr = mem_addr; end
                else begin vec_cnt++; last_vec = mem_wdata; last_vaddr = mem_addr; end
                mem_ready = 1;
            end
        end
    end

    initial forever begin
        @(negedge clk);
        if (irq_msg) msg_cnt++;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] exp_w;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        reg_read(3'd0, rd); chk("R11 ctrl reset", rd, 0);
        reg_read(3'd4, rd); chk("R11 wptr reset", rd, 0);
        chk("R11 outputs reset", {evt_ready, busy, irq_pending, irq_msg, mem_valid}, 0);

        // R3 disabled ring takes nothing
        reg_write(3'd0, 32'h08);
        evt_valid = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3 ready low when disabled", {evt_ready, busy}, 0);
        end
        evt_valid = 0;
        chk("R3 no memory write when disabled", vec_cnt, 0);

        reg_write(3'd2, BASE_ADDR[39:8]);
        reg_write(3'd1, 32'h1);
        reg_write(3'd0, CTRL_RUN);

        // table walk: R1 layout, R2 address and advance, R4 overflow at wrap
        exp_w = 0;
        foreach (TBL[i]) begin
            send_event(TBL[i]);
            wait_idle();
            chk("R2 vector address", last_vaddr, BASE_ADDR + 40'(exp_w[17:0]));
            chk("R1 vector layout", last_vec,
                pack(TBL[i][99:92], TBL[i][91:64], TBL[i][63:56], TBL[i][55:48], TBL[i][47:32]));
            reg_read(3'd4, rd); chk("R2 R4 write pointer", rd, TBL[i][31:0]);
            exp_w = TBL[i][31:0];
        end
        chk("R8 single message for first entry", msg_cnt, 1);
        chk("R7 idle after overflow wrap", irq_pending, 0);
        reg_read(3'd4, rd); chk("R5 flag persists", rd, 32'h8000_0000);

        // R5 clear
        reg_write(3'd0, CTRL_RUN | 32'h80);
        @(negedge clk);
        reg_read(3'd4, rd); chk("R5 flag cleared", rd, 0);
        reg_write(3'd0, CTRL_RUN);
        reg_read(3'd4, rd); chk("R5 flag stays clear", rd, 0);

        // R9 rearm
        reg_write(3'd1, 32'h3);
        send_event(TBL[0]); wait_idle();
        chk("R8 message on idle to busy", msg_cnt, 2);
        chk("R7 pending", irq_pending, 1);
        reg_write(3'd3, 32'h0); @(negedge clk);
        chk("R9 rearm message", msg_cnt, 3);
        reg_write(3'd3, 32'h10); @(negedge clk);
        chk("R9 no message when idle", msg_cnt, 3);
        chk("R7 not pending when equal", irq_pending, 0);
        reg_write(3'd1, 32'h1);
        send_event(TBL[1]); wait_idle();
        chk("R8 message again", msg_cnt, 4);
        reg_write(3'd3, 32'h10); @(negedge clk);
        chk("R9 no message without rearm", msg_cnt, 4);
        chk("R7 still pending", irq_pending, 1);

        // R6 writeback
        reg_write(3'd5, 32'h1400);
        reg_write(3'd0, CTRL_RUN | 32'h100);
        send_event(TBL[2]); wait_idle();
        chk("R6 writeback count", wb_cnt, 1);
        chk("R6 writeback address", last_wbaddr, 40'h5000);
        chk("R6 writeback value", last_wb, 32'h30);
        chk("R2 address after wrap", last_vaddr, BASE_ADDR + 40'h20);

        // same-cycle commit and read-pointer write (R4 R7 R11)
        hold_ready = 1;
        send_event(TBL[3]);
        chk("R11 busy while outstanding", {busy, mem_valid, evt_ready}, 3'b110);
        mem_ready = 1;
        reg_wr = 1; reg_addr = 3'd3; reg_wdata = 0;
        @(negedge clk);
        mem_ready = 0; reg_wr = 0;
        #1 hold_ready = 0;
        wait_idle();
        reg_read(3'd4, rd); chk("R4 overflow against new read pointer", rd, 32'h8000_0000);
        reg_read(3'd3, rd); chk("R10 read pointer", rd, 0);
        chk("R7 idle after same-cycle", irq_pending, 0);
        chk("R8 no extra message", msg_cnt, 4);
        chk("R6 writeback carries flag", last_wb, 32'h8000_0000);

        // R10 masking
        reg_write(3'd3, 32'h3FFF5);
        reg_read(3'd3, rd); chk("R10 masked read pointer", rd, 32'h35);
        reg_write(3'd4, 32'h3FFE0);
        reg_read(3'd4, rd); chk("R10 masked write pointer", rd, 32'h8000_0020);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule